// File: doc/BRIEF.md
# Bidirectional GPIO Port with PWM Override

This block is an 8-bit general-purpose I/O port that sits on a simple register bus. Each pin has a direction bit that enables or disables its output driver, and an output latch that holds the value the pin drives. The bus reads back three views of the port: the stored latch value, the direction bits, and the live pin level after a two-flop synchronizer. Software can therefore tell the value it asked for apart from the value actually present on the pad.

The three most significant pins can be handed to a PWM peripheral. While the peripheral's select input is high, those pins drive the peripheral's data instead of the latch. The block also resolves the parallel-slave mode request. The mode is granted only when the PWM peripheral is not running one of its multi-output modes. While the mode is granted, the pad input buffers are switched to TTL thresholds.

Top module: `gpio_port`

## Requirements
- R1: While reset is high, and in the first cycle after it, the direction register is all ones (every pin an input, `pin_oe` = 0x00) and the output latch is 0x00.
- R2: A bus write to address 2 loads the direction register on that clock edge. From the next cycle on, `pin_oe` bit i equals the inverse of direction bit i (0 = output, 1 = input), and a read of address 2 returns the written value.
- R3: A bus write to address 1 (latch) or to address 0 (port) loads the output latch. A read of address 1 returns the latch value whatever the pin levels are.
- R4: A read of address 0 returns `pin_in` as it was two clock edges earlier, and never the latch value.
- R5: For pins 4:0, `pin_out` always carries the latch bit. For pins 7:5, `pin_out` carries the latch bit while `pwm_sel` is 0.
- R6: While `pwm_sel` is 1, `pin_out[7:5]` equals `pwm_data[2:0]`. Pins 4:0 and the direction bits are unaffected.
- R7: `psp_active` and `ttl_in_sel` are 1 exactly when `psp_mode_req` is 1 and `pwm_multi` is 0.
- R8: A read of address 3 returns 0x00. A write to address 3 changes neither the latch nor the direction register.
- R9: Writing 0xCF to the direction register gives `pin_oe` = 0x30 (bits 5:4 outputs, all other bits inputs).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 2 | Register address: 0 port, 1 latch, 2 direction |
| bus_wr | input | 1 | Write strobe, sampled at the rising clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| pin_in | input | 8 | Pad input levels |
| pin_out | output | 8 | Pad output data |
| pin_oe | output | 8 | Pad output enable, 1 = drive |
| pwm_data | input | 3 | PWM peripheral outputs for pins 7:5 |
| pwm_sel | input | 1 | 1 = pins 7:5 take `pwm_data` |
| psp_mode_req | input | 1 | Parallel-slave mode request |
| pwm_multi | input | 1 | PWM runs in dual or quad output mode |
| psp_active | output | 1 | Parallel-slave mode granted |
| ttl_in_sel | output | 1 | 1 = TTL input thresholds, 0 = Schmitt trigger |

## Verification
The bench targets the places where the read views could be confused. A design that returned the latch on a port read, or the pins on a latch read, would fail as soon as `pin_in` and the latch differ. A synchronizer that is one stage short or one stage long would show the new pin value one cycle early or one cycle late. Writes to the port address must land in the latch, and a write to the unused address must leave every register alone. The bench also checks the override boundary: an off-by-one split would leak `pwm_data` onto pin 4 or leave pin 5 on the latch. A missing multi-output veto would grant the parallel-slave mode while `pwm_multi` is high.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
    localparam int PORT_W  = 8;
    localparam int ADDR_W  = 2;

    typedef enum logic [ADDR_W-1:0] {
        REG_PIN = 2'd0,
        REG_OUT = 2'd1,
        REG_DIR = 2'd2
    } reg_sel_e;

    typedef struct packed {
        logic [PORT_W-1:0] dir;
        logic [PORT_W-1:0] lat;
    } port_cfg_t;

    function automatic logic hits_latch(input logic [ADDR_W-1:0] a);
        return (a == REG_PIN) || (a == REG_OUT);
    endfunction

    function automatic logic is_mapped(input logic [ADDR_W-1:0] a);
        return hits_latch(a) || (a == REG_DIR);
    endfunction
endpackage

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [PORT_W-1:0] wdata,
    output port_cfg_t         cfg
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg.dir <= '1;
            cfg.lat <= '0;
        end else if (wr) begin
            if (hits_latch(addr)) cfg.lat <= wdata;
            if (addr == REG_DIR)  cfg.dir <= wdata;
        end
    end

    assert_reset_state_R1: assert property (@(posedge clk)
        $past(rst) |-> (cfg.dir == '1 && cfg.lat == '0));

    assert_dir_load_R2: assert property (@(posedge clk) disable iff (rst)
        (wr && addr == REG_DIR) |=> cfg.dir == $past(wdata));

    assert_lat_load_R3: assert property (@(posedge clk) disable iff (rst)
        (wr && hits_latch(addr)) |=> cfg.lat == $past(wdata));

    assert_unmapped_write_R8: assert property (@(posedge clk) disable iff (rst)
        (wr && !is_mapped(addr)) |=> ($stable(cfg.lat) && $stable(cfg.dir)));
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    for (genvar i = 0; i < W; i++) begin : g_bit
        always_ff @(posedge clk) begin
            stage1[i] <= d[i];
            q[i]      <= stage1[i];
        end
    end

    logic [1:0] fill_cnt;
    always_ff @(posedge clk) begin
        if (rst)                fill_cnt <= '0;
        else if (fill_cnt != 2) fill_cnt <= fill_cnt + 2'd1;
    end

    assert_two_stage_R4: assert property (@(posedge clk) disable iff (rst)
        (fill_cnt == 2) |-> q == $past(d, 2));
endmodule

// File: rtl/gpio_pinmux.sv
module gpio_pinmux #(
    parameter int W     = 8,
    parameter int OVR_N = 3
) (
    input  logic [W-1:0]     lat,
    input  logic [W-1:0]     dir,
    input  logic [OVR_N-1:0] pwm_data,
    input  logic             pwm_sel,
    output logic [W-1:0]     pin_out,
    output logic [W-1:0]     pin_oe
);
    localparam int OVR_LO = W - OVR_N;

    for (genvar i = 0; i < W; i++) begin : g_pin
        if (i >= OVR_LO) begin : g_ovr
            assign pin_out[i] = pwm_sel ? pwm_data[i-OVR_LO] : lat[i];
        end else begin : g_plain
            assign pin_out[i] = lat[i];
        end
        assign pin_oe[i] = ~dir[i];
    end

    always_comb begin
        assert_low_pins_R5: assert (pin_out[OVR_LO-1:0] == lat[OVR_LO-1:0]);
    end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_port_pkg::*;
#(
    parameter int OVR_N = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [PORT_W-1:0] bus_wdata,
    output logic [PORT_W-1:0] bus_rdata,
    input  logic [PORT_W-1:0] pin_in,
    output logic [PORT_W-1:0] pin_out,
    output logic [PORT_W-1:0] pin_oe,
    input  logic [OVR_N-1:0]  pwm_data,
    input  logic              pwm_sel,
    input  logic              psp_mode_req,
    input  logic              pwm_multi,
    output logic              psp_active,
    output logic              ttl_in_sel
);
    port_cfg_t         cfg;
    logic [PORT_W-1:0] pin_sync;

    gpio_regs u_regs (
        .clk(clk), .rst(rst), .wr(bus_wr), .addr(bus_addr),
        .wdata(bus_wdata), .cfg(cfg)
    );

    gpio_sync #(.W(PORT_W)) u_sync (
        .clk(clk), .rst(rst), .d(pin_in), .q(pin_sync)
    );

    gpio_pinmux #(.W(PORT_W), .OVR_N(OVR_N)) u_mux (
        .lat(cfg.lat), .dir(cfg.dir), .pwm_data(pwm_data),
        .pwm_sel(pwm_sel), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    always_comb begin
        case (bus_addr)
            REG_PIN: bus_rdata = pin_sync;
            REG_OUT: bus_rdata = cfg.lat;
            REG_DIR: bus_rdata = cfg.dir;
            default: bus_rdata = '0;
        endcase
    end

    assign psp_active = psp_mode_req & ~pwm_multi;
    assign ttl_in_sel = psp_active;

    assert_psp_veto_R7: assert property (@(posedge clk) disable iff (rst)
        pwm_multi |-> (!psp_active && !ttl_in_sel));

    assert_oe_follows_R2: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == REG_DIR) |=> pin_oe == ~$past(bus_wdata));
endmodule

// File: tb/gpio_port_tb_top.sv
module gpio_port_tb_top;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] pin_in = 8'h00;
    logic [7:0] pin_out, pin_oe;
    logic [2:0] pwm_data = '0;
    logic       pwm_sel = 1'b0;
    logic       psp_mode_req = 1'b0;
    logic       pwm_multi = 1'b0;
    logic       psp_active, ttl_in_sel;

    int n_tests = 0;
    int n_fail  = 0;

    logic [7:0] m_lat, m_dir, m_s1, m_s2;
    int         m_steps = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    gpio_port dut_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .pwm_data(pwm_data),
        .pwm_sel(pwm_sel), .psp_mode_req(psp_mode_req),
        .pwm_multi(pwm_multi), .psp_active(psp_active),
        .ttl_in_sel(ttl_in_sel)
    );

    function automatic logic [7:0] exp_out(input logic [7:0] lat,
                                           input logic sel,
                                           input logic [2:0] pwm);
        return sel ? {pwm, lat[4:0]} : lat;
    endfunction

    function automatic logic [7:0] exp_rd(input logic [1:0] a);
        case (a)
            2'd0:    return m_s2;
            2'd1:    return m_lat;
            2'd2:    return m_dir;
            default: return 8'h00;
        endcase
    endfunction

    task automatic chk(input string req, input logic [7:0] act,
                       input logic [7:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    // one clock edge: model update, then check at the falling edge
    task automatic step();
        @(posedge clk);
        if (rst) begin
            m_lat = 8'h00; m_dir = 8'hFF;
        end else if (bus_wr) begin
            if (bus_addr == 2'd0 || bus_addr == 2'd1) m_lat = bus_wdata;
            if (bus_addr == 2'd2) m_dir = bus_wdata;
        end
        m_s2 = m_s1;
        m_s1 = pin_in;
        m_steps++;
        @(negedge clk);
        if (!rst) begin
            chk("R5/R6 pin_out", pin_out, exp_out(m_lat, pwm_sel, pwm_data));
            chk("R2 pin_oe", pin_oe, ~m_dir);
            chk("R7 psp_active", {7'b0, psp_active},
                {7'b0, psp_mode_req & ~pwm_multi});
            chk("R7 ttl_in_sel", {7'b0, ttl_in_sel},
                {7'b0, psp_mode_req & ~pwm_multi});
            if (bus_addr != 2'd0 || m_steps >= 3)
                chk("R3/R4/R8 rdata", bus_rdata, exp_rd(bus_addr));
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
        step();
        bus_wr = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        m_s1 = 8'h00; m_s2 = 8'h00;
        step(); step();
        rst = 1'b0;
        step();
        // R1: reset state visible in the first cycle after reset
        chk("R1 oe after reset", pin_oe, 8'h00);
        bus_addr = 2'd1; #1; chk("R1 latch after reset", bus_rdata, 8'h00);
        bus_addr = 2'd2; #1; chk("R1 dir after reset", bus_rdata, 8'hFF);

        // R9: direction pattern
        bus_write(2'd2, 8'hCF);
        chk("R9 oe for CF", pin_oe, 8'h30);

        // R3: port-address write lands in latch; latch read ignores pins
        pin_in = 8'h5A;
        bus_write(2'd0, 8'hA5);
        bus_addr = 2'd1; #1; chk("R3 latch read", bus_rdata, 8'hA5);

        // R4: exactly two-edge latency on port read
        pin_in = 8'h3C;
        bus_addr = 2'd0;
        step();
        chk("R4 one edge not yet", bus_rdata, 8'h5A);
        step();
        chk("R4 two edges", bus_rdata, 8'h3C);

        // R8: unmapped address
        bus_write(2'd3, 8'h77);
        bus_addr = 2'd3; #1; chk("R8 read zero", bus_rdata, 8'h00);
        bus_addr = 2'd1; #1; chk("R8 latch kept", bus_rdata, 8'hA5);
        bus_addr = 2'd2; #1; chk("R8 dir kept", bus_rdata, 8'hCF);

        // R6: override boundary
        bus_write(2'd1, 8'h00);
        pwm_data = 3'b111; pwm_sel = 1'b1; #1;
        chk("R6 override", pin_out, 8'hE0);
        pwm_sel = 1'b0; #1;
        chk("R5 no override", pin_out, 8'h00);

        // R7: multi-output veto
        psp_mode_req = 1'b1; pwm_multi = 1'b1; #1;
        chk("R7 vetoed", {7'b0, psp_active}, 8'h00);
        pwm_multi = 1'b0; #1;
        chk("R7 granted", {7'b0, ttl_in_sel}, 8'h01);

        // constrained random mix
        for (int k = 0; k < 400; k++) begin
            bus_addr     = 2'($urandom_range(0, 3));
            bus_wr       = ($urandom_range(0, 2) == 0);
            bus_wdata    = 8'($urandom);
            pin_in       = 8'($urandom);
            pwm_data     = 3'($urandom);
            pwm_sel      = 1'($urandom);
            psp_mode_req = 1'($urandom);
            pwm_multi    = 1'($urandom);
            step();
        end
        bus_wr = 1'b0;

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule